// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block is the read side of a one-bit-wide configuration store. A fixed array of bits, computed when the design is elaborated, is presented one bit at a time on a single data line. An internal address counter moves forward on each rising clock edge while the device is selected and enabled. A reader samples each bit on the rising edge that follows its appearance, and that same edge moves the store on to the next bit.

Several stores can share one data line in a chain. The hand-off output of each store feeds the active-low select input of the next store. When the last stored bit has been consumed, the store stops driving the line and pulls its hand-off output low on the same edge, so the next device starts driving at once. One pin serves as both reset and output enable, and a parameter sets the level at which that pin means reset. The shared line is modelled as a data value plus a drive-enable, so a bench or wrapper can resolve the bus.

Top module: `serial_cfg_store`

## Requirements
- R1: While `sel_n` is 0 and the reset/enable pin is not in its reset level, each rising clock edge advances the read position by exactly one. After each edge, `bit_out` carries the stored bit at the new position with `bit_drive` = 1.
- R2: While the reset/enable pin is at its reset level, `bit_drive` is 0 and the read position is held at 0, whatever happens on the clock. On release, `bit_out` shows stored bit 0 before any further clock edge.
- R3: With `RST_LEVEL_HIGH` = 1 a high level on `rst_oe` means reset. With `RST_LEVEL_HIGH` = 0 a low level means reset.
- R4: While `sel_n` is 1, the position does not change, `bit_drive` is 0 and `idle` is 1. `idle` is 0 while `sel_n` is 0.
- R5: Once all `DEPTH` bits have been read, the position saturates. `bit_drive` stays 0 from then on until a reset, however many further edges arrive.
- R6: Past the last bit and with the pin not in reset, `pass_n` equals `sel_n`. Before the last bit has been consumed, `pass_n` is 1.
- R7: When the reset/enable pin enters its reset level, `pass_n` goes to 1 at once. It stays 1 after release until the full `DEPTH` bits have been read again.
- R8: The stored bit at position a (0 ≤ a < `DEPTH`) is the XOR of the low 16 bits of a·`FILL_MUL` + `FILL_ADD`.
- R9: A store never drives its data line while its `pass_n` is 0. In a chain, the hand-off happens on the edge that consumes the last bit, so the next store's bit 0 appears on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; rising edges advance the position |
| rst_oe | input | 1 | Combined reset / output enable, reset level set by `RST_LEVEL_HIGH` |
| sel_n | input | 1 | Active-low select |
| bit_out | output | 1 | Serial data value (0 when not driving) |
| bit_drive | output | 1 | 1 when `bit_out` is driven onto the shared line |
| pass_n | output | 1 | Active-low hand-off to the next store's `sel_n` |
| idle | output | 1 | 1 while deselected (standby indication) |

## Verification
The hardest situation to reach is a pause in the middle of the stream at an arbitrary bit position, followed by a resume that has to continue exactly where it stopped. The bench sweeps the pause point over every position of a small store, including the position just past the last bit, and each time follows the stream through the hand-off into a second store that uses the opposite reset polarity. A separate pass drops the enable after the last bit. It then checks that the hand-off output stays high through a complete re-read.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;

    // Fill rule for the preloaded array: parity of the low 16 bits of a*mul+add.
    function automatic logic fill_bit(input int unsigned a,
                                      input int unsigned mul,
                                      input int unsigned add);
        logic [31:0] prod;
        prod = a * mul + add;
        return ^prod[15:0];
    endfunction

endpackage

// File: rtl/scs_bit_store.sv
`timescale 1ns/1ps
module scs_bit_store #(
    parameter int unsigned DEPTH    = 256,
    parameter int unsigned FILL_MUL = 5,
    parameter int unsigned FILL_ADD = 3,
    localparam int unsigned AW      = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0] rd_pos,
    output logic          rd_bit
);
    logic [DEPTH-1:0] cells;

    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        assign cells[i] = scs_pkg::fill_bit(i, FILL_MUL, FILL_ADD);
    end

    always_comb begin
        rd_bit = 1'b0;
        if (rd_pos < AW'(DEPTH)) begin
            rd_bit = cells[rd_pos];
        end
    end
endmodule

// File: rtl/scs_pos_ctr.sv
`timescale 1ns/1ps
module scs_pos_ctr #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          clear,
    input  logic          step_en,
    output logic [AW-1:0] pos,
    output logic          spent
);
    typedef struct packed {
        logic [AW-1:0] pos;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en && (st_q.pos != AW'(DEPTH))) begin
            st_d.pos = st_q.pos + AW'(1);
        end
    end

    always_ff @(posedge clk or posedge clear) begin
        if (clear) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos   = st_q.pos;
    assign spent = (st_q.pos == AW'(DEPTH));
endmodule

// File: rtl/scs_link_ctl.sv
`timescale 1ns/1ps
module scs_link_ctl (
    input  logic sel_on,
    input  logic en_on,
    input  logic spent,
    input  logic raw_bit,
    output logic bit_out,
    output logic bit_drive,
    output logic pass_n,
    output logic idle
);
    logic live;

    always_comb begin
        live      = sel_on && en_on;
        bit_drive = live && !spent;
        bit_out   = bit_drive ? raw_bit : 1'b0;
        pass_n    = !(live && spent);
        idle      = !sel_on;
    end
endmodule

// File: rtl/serial_cfg_store.sv
`timescale 1ns/1ps
module serial_cfg_store #(
    parameter int unsigned DEPTH          = 256,
    parameter bit          RST_LEVEL_HIGH = 1'b1,
    parameter int unsigned FILL_MUL       = 5,
    parameter int unsigned FILL_ADD       = 3,
    localparam int unsigned AW            = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_oe,
    input  logic sel_n,
    output logic bit_out,
    output logic bit_drive,
    output logic pass_n,
    output logic idle
);
    logic          rst_act;
    logic          sel_on;
    logic [AW-1:0] pos;
    logic          spent;
    logic          raw_bit;

    assign rst_act = (rst_oe == RST_LEVEL_HIGH);
    assign sel_on  = !sel_n;

    scs_pos_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk     (clk),
        .clear   (rst_act),
        .step_en (sel_on),
        .pos     (pos),
        .spent   (spent)
    );

    scs_bit_store #(.DEPTH(DEPTH), .FILL_MUL(FILL_MUL), .FILL_ADD(FILL_ADD)) u_store (
        .rd_pos (pos),
        .rd_bit (raw_bit)
    );

    scs_link_ctl u_link (
        .sel_on    (sel_on),
        .en_on     (!rst_act),
        .spent     (spent),
        .raw_bit   (raw_bit),
        .bit_out   (bit_out),
        .bit_drive (bit_drive),
        .pass_n    (pass_n),
        .idle      (idle)
    );
endmodule

// File: rtl/scs_checker.sv
`timescale 1ns/1ps
module scs_checker #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_act,
    input logic          sel_n,
    input logic [AW-1:0] pos,
    input logic          bit_drive,
    input logic          pass_n
);
    // R1: one step per enabled edge
    p_step_r1: assert property (@(posedge clk) disable iff (rst_act)
        ($past(!rst_act) && $past(!sel_n) && $past(pos) != AW'(DEPTH)) |-> pos == $past(pos) + AW'(1));

    // R2: first edge after release sees position zero
    p_start_zero_r2: assert property (@(posedge clk) disable iff (rst_act)
        $past(rst_act) |-> pos == '0);

    // R4: deselected means no movement
    p_hold_r4: assert property (@(posedge clk) disable iff (rst_act)
        ($past(!rst_act) && $past(sel_n)) |-> $stable(pos));

    // R5: saturation past the last bit
    p_saturate_r5: assert property (@(posedge clk) disable iff (rst_act)
        ($past(!rst_act) && $past(pos) == AW'(DEPTH)) |-> pos == AW'(DEPTH));

    // R5: no drive once spent
    p_quiet_spent_r5: assert property (@(posedge clk) disable iff (rst_act)
        pos == AW'(DEPTH) |-> !bit_drive);

    // R7: hand-off only after a full read
    p_pass_after_end_r7: assert property (@(posedge clk) disable iff (rst_act)
        !pass_n |-> pos == AW'(DEPTH));

    // R9: never drive and hand off together
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst_act)
        !(bit_drive && !pass_n));
endmodule

bind serial_cfg_store scs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_act   (rst_act),
    .sel_n     (sel_n),
    .pos       (pos),
    .bit_drive (bit_drive),
    .pass_n    (pass_n)
);

// File: tb/serial_cfg_store_test.sv
`timescale 1ns/1ps
module serial_cfg_store_test;
    localparam int DU = 20;
    localparam int DN = 12;

    logic clk = 1'b0;
    logic rst_hi;
    logic sel0_n;
    logic u_bit, u_drv, u_pass, u_idle;
    logic n_bit, n_drv, n_pass, n_idle;
    logic bus;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    serial_cfg_store #(.DEPTH(DU), .RST_LEVEL_HIGH(1'b1), .FILL_MUL(5), .FILL_ADD(3)) uut (
        .clk(clk), .rst_oe(rst_hi), .sel_n(sel0_n),
        .bit_out(u_bit), .bit_drive(u_drv), .pass_n(u_pass), .idle(u_idle));

    serial_cfg_store #(.DEPTH(DN), .RST_LEVEL_HIGH(1'b0), .FILL_MUL(7), .FILL_ADD(1)) nxt (
        .clk(clk), .rst_oe(!rst_hi), .sel_n(u_pass),
        .bit_out(n_bit), .bit_drive(n_drv), .pass_n(n_pass), .idle(n_idle));

    always_comb bus = u_drv ? u_bit : (n_drv ? n_bit : 1'bz);

    function automatic logic ref_bit(input int a, input int mul, input int add);
        logic [31:0] v;
        v = a * mul + add;
        return ^v[15:0];
    endfunction

    task automatic chk(input logic ok, input string req, input logic act, input logic exp);
        total++;
        if (ok !== 1'b1) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 50000);
        total++;
        bad++;
        $display("FAIL watchdog act=1 exp=0");
        finish_run();
    end

    initial begin
        rst_hi = 1'b1;
        sel0_n = 1'b0;
        repeat (3) tick();
        // R2/R3 reset state on both polarities
        chk(u_drv == 1'b0, "R2 drive in reset", u_drv, 1'b0);
        chk(u_pass == 1'b1, "R7 pass in reset", u_pass, 1'b1);
        chk(n_drv == 1'b0, "R3 low-level reset drive", n_drv, 1'b0);
        chk(n_pass == 1'b1, "R3 low-level reset pass", n_pass, 1'b1);
        chk(u_idle == 1'b0, "R4 idle while selected", u_idle, 1'b0);
        chk(n_idle == 1'b1, "R4 idle while deselected", n_idle, 1'b1);

        for (int p = 0; p <= DU; p++) begin
            rst_hi = 1'b1;
            repeat (3) tick();
            rst_hi = 1'b0;
            #1;
            chk(bus === ref_bit(0, 5, 3), "R2 bit0 after release", bus, ref_bit(0, 5, 3));
            for (int k = 0; k < p; k++) begin
                chk(u_drv == 1'b1, "R1 drive", u_drv, 1'b1);
                chk(bus === ref_bit(k, 5, 3), "R8 stored bit", bus, ref_bit(k, 5, 3));
                tick();
            end
            sel0_n = 1'b1;
            #1;
            chk(u_drv == 1'b0, "R4 no drive deselected", u_drv, 1'b0);
            chk(u_idle == 1'b1, "R4 idle flag", u_idle, 1'b1);
            chk(u_pass == 1'b1, "R6 pass follows sel", u_pass, 1'b1);
            tick();
            tick();
            sel0_n = 1'b0;
            #1;
            for (int k = p; k < DU; k++) begin
                chk(bus === ref_bit(k, 5, 3), "R1 resume position", bus, ref_bit(k, 5, 3));
                chk(u_pass == 1'b1, "R6 pass before end", u_pass, 1'b1);
                tick();
            end
            chk(u_drv == 1'b0, "R5 quiet after end", u_drv, 1'b0);
            chk(u_pass == 1'b0, "R9 hand-off", u_pass, 1'b0);
            for (int k = 0; k < DN; k++) begin
                chk(n_drv == 1'b1, "R9 next drives", n_drv, 1'b1);
                chk(bus === ref_bit(k, 7, 1), "R9 next stored bit", bus, ref_bit(k, 7, 1));
                tick();
            end
            chk(n_drv == 1'b0, "R5 next quiet", n_drv, 1'b0);
            chk(n_pass == 1'b0, "R9 next hand-off", n_pass, 1'b0);
            repeat (4) tick();
            chk(u_drv == 1'b0 && n_drv == 1'b0, "R5 saturation", u_drv | n_drv, 1'b0);
            chk(u_pass == 1'b0, "R5 no wrap", u_pass, 1'b0);
            sel0_n = 1'b1;
            #1;
            chk(u_pass == 1'b1, "R6 follow high", u_pass, 1'b1);
            chk(n_idle == 1'b1, "R4 next idle", n_idle, 1'b1);
            sel0_n = 1'b0;
            #1;
            chk(u_pass == 1'b0, "R6 follow low", u_pass, 1'b0);
        end

        // R7: drop enable after end, pass stays high through a full re-read
        rst_hi = 1'b1;
        #1;
        chk(u_pass == 1'b1, "R7 pass forced high", u_pass, 1'b1);
        repeat (5) tick();
        rst_hi = 1'b0;
        #1;
        chk(u_pass == 1'b1, "R7 pass stays high", u_pass, 1'b1);
        chk(bus === ref_bit(0, 5, 3), "R2 held at zero", bus, ref_bit(0, 5, 3));
        for (int k = 0; k < DU; k++) begin
            chk(u_pass == 1'b1, "R7 high during re-read", u_pass, 1'b1);
            tick();
        end
        chk(u_pass == 1'b0, "R7 low after re-read", u_pass, 1'b0);

        finish_run();
    end
endmodule